// File: doc/BRIEF.md
# Audio Controller Global Control Sequencer

This block is the global register slice of a serial-link audio host controller. It presents a read-only identity word. That word packs the stream counts, the data-out line encoding, the wide-address flag and a version. It also holds a read-write control word whose lowest bit is the controller's run/reset handshake. Software clears that bit to push the controller into reset and sets it to bring the controller out again. The bit reads back its new value only after a fixed, parameterised sequencing time has passed. The link reset output follows the handshake at once.

While the controller is held in reset, the control and flush state is forced to zero and writes to it are discarded. The wake-enable and wake-status registers are the exception: only power-on reset clears them. The block also runs a flush handshake toward the stream engines, and only while every stream and ring engine is stopped. It gates unsolicited codec responses, accepting them or dropping them according to an enable bit.

Top module: `acg_top`

## Requirements
- R1: The word at offset 0x00 reads {major version byte, minor version byte, 16-bit capability}. In the capability, bits 15:12 are the output stream count, 11:8 the input stream count and 7:3 the bidirectional stream count. Bits 2:1 are the data-out line code (00 one, 01 two, 10 four) and bit 0 is the wide-address flag. All fields come from parameters.
- R2: After power-on reset (por_n low), the control word at 0x08 reads 0 and link_rst_n is 0.
- R3: Writing 1 to control bit 0 while bit 0 reads 0 and no sequence is running raises link_rst_n in the cycle after the write edge. Bit 0 keeps reading 0 until EXIT_CYC clock edges after the write edge, and reads 1 from then on.
- R4: Writing 0 to control bit 0 while running lowers link_rst_n in the cycle after the write edge. It clears the unsolicited enable, any flush in progress and the flush status at once. Bit 0 reads 1 until ENTER_CYC edges after the write edge, then reads 0.
- R5: Unless the controller is fully running, writes to control bits 1 and 8 and to the flush status are discarded. Writes to bit 0 during an entry or exit sequence are discarded as well.
- R6: Wake enable (0x0C, WAKE_W bits) and wake status (0x10) are writable in every state and survive controller reset. Only por_n clears them. A wake status bit is set by the matching codec_wake input and cleared by writing 1 to it.
- R7: Control bits 31:9 and 7:2 always read 0, whatever is written to them.
- R8: unsol_accept equals unsol_valid while control bit 8 is 1, and is 0 while bit 8 is 0.
- R9: Writing 1 to control bit 1 while all stream_run and ring_run inputs are low raises flush_req in the next cycle, and bit 1 reads 1 while the flush is open. The edge that samples flush_done drops flush_req and sets flush status (0x14 bit 0).
- R10: A flush write is ignored while any stream_run or ring_run input is high.
- R11: Flush status is sticky. Writing 1 to 0x14 bit 0 clears it, and writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| link_rst_n | output | 1 | Link reset, active low |
| stream_run | input | NUM_STREAMS | Run status of each stream engine |
| ring_run | input | 2 | Run status of the command and response rings |
| flush_req | output | 1 | Flush request to the stream engines |
| flush_done | input | 1 | Flush completion pulse |
| unsol_valid | input | 1 | Unsolicited response offered |
| unsol_accept | output | 1 | Unsolicited response taken into the response path |
| codec_wake | input | WAKE_W | Per-codec wake event inputs |

## Verification
The bench counts edges around both reset sequence directions. An off-by-one counter would show bit 0 flipping one cycle early or late. A design that drove link reset from the read-back bit would lag by the whole sequence. Writes that try to set the enable and flush bits while in reset, or together with a reset request, are checked to have left no trace. The wake registers are checked across a full controller reset and then across power-on reset. Flush is attempted while a stream is running and while a ring is running, which catches a gate that checks only one kind of run input. The sticky status is checked against a write of 0, which a clear-on-any-write design would wrongly clear.

// File: rtl/acg_pkg.sv
package acg_pkg;

  typedef enum logic [1:0] {
    RS_HOLD  = 2'd0,
    RS_EXIT  = 2'd1,
    RS_RUN   = 2'd2,
    RS_ENTER = 2'd3
  } rst_state_e;

  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_ID        = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CTL       = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_WAKE_EN   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_WAKE_STS  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_FLUSH_STS = 8'h14;

  localparam int CTL_RUN_BIT   = 0;
  localparam int CTL_FLUSH_BIT = 1;
  localparam int CTL_UNSOL_BIT = 8;

  function automatic logic [15:0] cap_pack(input int n_out, input int n_in,
                                           input int n_bidir, input int sdo_code,
                                           input int wide_addr);
    logic [15:0] w;
    w[15:12] = 4'(n_out);
    w[11:8]  = 4'(n_in);
    w[7:3]   = 5'(n_bidir);
    w[2:1]   = 2'(sdo_code);
    w[0]     = (wide_addr != 0);
    return w;
  endfunction

  // Bit 0 reads 1 while running and during the entry sequence.
  function automatic logic run_bit_view(input rst_state_e st);
    return (st == RS_RUN) || (st == RS_ENTER);
  endfunction

  function automatic logic [31:0] ctl_pack(input logic unsol, input logic flush,
                                           input logic run);
    logic [31:0] w;
    w = '0;
    w[CTL_UNSOL_BIT] = unsol;
    w[CTL_FLUSH_BIT] = flush;
    w[CTL_RUN_BIT]   = run;
    return w;
  endfunction

endpackage

// File: rtl/acg_rst_seq.sv
module acg_rst_seq
  import acg_pkg::*;
#(
  parameter int ENTER_CYC = 8,
  parameter int EXIT_CYC  = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic go_run,
  input  logic go_reset,
  output logic link_rst_n,
  output logic run_bit,
  output logic regs_live,
  output logic entry_pulse
);
  localparam int MAX_CYC = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] ENTER_LOAD = CNT_W'(ENTER_CYC - 1);
  localparam logic [CNT_W-1:0] EXIT_LOAD  = CNT_W'(EXIT_CYC - 1);

  rst_state_e st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      st  <= RS_HOLD;
      cnt <= '0;
    end else begin
      case (st)
        RS_HOLD:  if (go_run) begin st <= RS_EXIT; cnt <= EXIT_LOAD; end
        RS_EXIT:  if (cnt == '0) st <= RS_RUN; else cnt <= cnt - 1'b1;
        RS_RUN:   if (go_reset) begin st <= RS_ENTER; cnt <= ENTER_LOAD; end
        default:  if (cnt == '0) st <= RS_HOLD; else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign link_rst_n  = (st == RS_EXIT) || (st == RS_RUN);
  assign run_bit     = run_bit_view(st);
  assign regs_live   = (st == RS_RUN);
  assign entry_pulse = (st == RS_RUN) && go_reset;
endmodule

// File: rtl/acg_flush.sv
module acg_flush #(
  parameter int NUM_STREAMS = 8
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   clear,
  input  logic                   start_wr,
  input  logic [NUM_STREAMS-1:0] stream_run,
  input  logic [1:0]             ring_run,
  input  logic                   flush_done,
  input  logic                   sts_clr_wr,
  output logic                   busy,
  output logic                   sts
);
  logic engines_idle;
  assign engines_idle = (stream_run == '0) && (ring_run == '0);

  always_ff @(posedge clk) begin
    if (!por_n || clear) begin
      busy <= 1'b0;
      sts  <= 1'b0;
    end else begin
      if (busy && flush_done) begin
        busy <= 1'b0;
        sts  <= 1'b1;
      end else begin
        if (start_wr && !busy && engines_idle) busy <= 1'b1;
        if (sts_clr_wr) sts <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/acg_wake.sv
module acg_wake #(
  parameter int WAKE_W = 15
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              en_wr,
  input  logic              sts_wr,
  input  logic [WAKE_W-1:0] wval,
  input  logic [WAKE_W-1:0] codec_wake,
  output logic [WAKE_W-1:0] wake_en,
  output logic [WAKE_W-1:0] wake_sts
);
  logic [WAKE_W-1:0] clr_mask;
  assign clr_mask = sts_wr ? wval : '0;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      wake_en  <= '0;
      wake_sts <= '0;
    end else begin
      if (en_wr) wake_en <= wval;
      wake_sts <= (wake_sts & ~clr_mask) | codec_wake;
    end
  end
endmodule

// File: rtl/acg_top.sv
module acg_top
  import acg_pkg::*;
#(
  parameter int OUT_STREAMS   = 4,
  parameter int IN_STREAMS    = 4,
  parameter int BIDIR_STREAMS = 0,
  parameter int SDO_CODE      = 0,
  parameter int ADDR64        = 1,
  parameter int VER_MAJOR     = 1,
  parameter int VER_MINOR     = 0,
  parameter int ENTER_CYC     = 8,
  parameter int EXIT_CYC      = 4,
  parameter int NUM_STREAMS   = 8,
  parameter int WAKE_W        = 15
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   wr_en,
  input  logic [7:0]             addr,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  output logic                   link_rst_n,
  input  logic [NUM_STREAMS-1:0] stream_run,
  input  logic [1:0]             ring_run,
  output logic                   flush_req,
  input  logic                   flush_done,
  input  logic                   unsol_valid,
  output logic                   unsol_accept,
  input  logic [WAKE_W-1:0]      codec_wake
);
  localparam logic [31:0] ID_WORD =
    {8'(VER_MAJOR), 8'(VER_MINOR),
     cap_pack(OUT_STREAMS, IN_STREAMS, BIDIR_STREAMS, SDO_CODE, ADDR64)};

  logic hit_ctl, hit_wen, hit_wsts, hit_fsts;
  logic go_run, go_reset, run_bit, regs_live, entry_pulse;
  logic ctl_live_wr, ctl_clear, flush_busy, flush_sts, unsol_en;
  logic [WAKE_W-1:0] wake_en, wake_sts;

  assign hit_ctl  = wr_en && (addr == OFS_CTL);
  assign hit_wen  = wr_en && (addr == OFS_WAKE_EN);
  assign hit_wsts = wr_en && (addr == OFS_WAKE_STS);
  assign hit_fsts = wr_en && (addr == OFS_FLUSH_STS) && regs_live;
  assign go_run   = hit_ctl &&  wdata[CTL_RUN_BIT];
  assign go_reset = hit_ctl && !wdata[CTL_RUN_BIT];
  assign ctl_live_wr = hit_ctl && regs_live && wdata[CTL_RUN_BIT];
  assign ctl_clear   = !regs_live || entry_pulse;

  acg_rst_seq #(.ENTER_CYC(ENTER_CYC), .EXIT_CYC(EXIT_CYC)) u_seq (
    .clk(clk), .por_n(por_n), .go_run(go_run), .go_reset(go_reset),
    .link_rst_n(link_rst_n), .run_bit(run_bit), .regs_live(regs_live),
    .entry_pulse(entry_pulse)
  );

  acg_flush #(.NUM_STREAMS(NUM_STREAMS)) u_flush (
    .clk(clk), .por_n(por_n), .clear(ctl_clear),
    .start_wr(ctl_live_wr && wdata[CTL_FLUSH_BIT]),
    .stream_run(stream_run), .ring_run(ring_run), .flush_done(flush_done),
    .sts_clr_wr(hit_fsts && wdata[0]), .busy(flush_busy), .sts(flush_sts)
  );

  acg_wake #(.WAKE_W(WAKE_W)) u_wake (
    .clk(clk), .por_n(por_n), .en_wr(hit_wen), .sts_wr(hit_wsts),
    .wval(wdata[WAKE_W-1:0]), .codec_wake(codec_wake),
    .wake_en(wake_en), .wake_sts(wake_sts)
  );

  always_ff @(posedge clk) begin
    if (!por_n || ctl_clear) unsol_en <= 1'b0;
    else if (ctl_live_wr)    unsol_en <= wdata[CTL_UNSOL_BIT];
  end

  assign flush_req    = flush_busy;
  assign unsol_accept = unsol_valid && unsol_en;

  always_comb begin
    case (addr)
      OFS_ID:        rdata = ID_WORD;
      OFS_CTL:       rdata = ctl_pack(unsol_en, flush_busy, run_bit);
      OFS_WAKE_EN:   rdata = {{(32-WAKE_W){1'b0}}, wake_en};
      OFS_WAKE_STS:  rdata = {{(32-WAKE_W){1'b0}}, wake_sts};
      OFS_FLUSH_STS: rdata = {31'b0, flush_sts};
      default:       rdata = '0;
    endcase
  end
endmodule

// File: rtl/acg_chk.sv
module acg_chk #(
  parameter int NUM_STREAMS = 8,
  parameter int WAKE_W      = 15
) (
  input logic                   clk,
  input logic                   por_n,
  input logic                   wr_en,
  input logic [7:0]             addr,
  input logic                   link_rst_n,
  input logic                   run_bit,
  input logic                   regs_live,
  input logic [NUM_STREAMS-1:0] stream_run,
  input logic [1:0]             ring_run,
  input logic                   flush_req,
  input logic                   flush_done,
  input logic                   flush_sts,
  input logic                   unsol_valid,
  input logic                   unsol_accept,
  input logic [WAKE_W-1:0]      wake_en
);
  // R4
  crst_fall_after_link_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(run_bit) |-> (!link_rst_n && $past(!link_rst_n)));
  // R3
  crst_rise_after_link_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(run_bit) |-> (link_rst_n && $past(link_rst_n)));
  // R10
  flush_idle_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(flush_req) |-> $past((stream_run == '0) && (ring_run == '0)));
  // R9
  flush_sts_source_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(flush_sts) |-> $past(flush_req && flush_done));
  // R8
  unsol_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
    unsol_accept |-> (unsol_valid && regs_live));
  // R5
  quiet_in_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
    !run_bit |-> (!flush_req && !unsol_accept && !flush_sts));
  // R6
  wake_en_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    !(wr_en && addr == acg_pkg::OFS_WAKE_EN) |=> $stable(wake_en));
endmodule

bind acg_top acg_chk #(.NUM_STREAMS(NUM_STREAMS), .WAKE_W(WAKE_W)) u_chk (
  .clk(clk), .por_n(por_n), .wr_en(wr_en), .addr(addr),
  .link_rst_n(link_rst_n), .run_bit(run_bit), .regs_live(regs_live),
  .stream_run(stream_run), .ring_run(ring_run), .flush_req(flush_req),
  .flush_done(flush_done), .flush_sts(flush_sts), .unsol_valid(unsol_valid),
  .unsol_accept(unsol_accept), .wake_en(wake_en)
);

// File: tb/tb_acg_top.sv
`timescale 1ns/1ps
module tb_acg_top;
  localparam int NS = 8, WW = 15, ENT = 6, EXT = 3;
  localparam int P_OUT = 5, P_IN = 3, P_BI = 6, P_SDO = 2, P_A64 = 1;
  localparam int P_MAJ = 1, P_MIN = 2;

  logic clk = 0, por_n = 0, wr_en = 0, flush_done = 0, unsol_valid = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic link_rst_n, flush_req, unsol_accept;
  logic [NS-1:0] stream_run = 0;
  logic [1:0] ring_run = 0;
  logic [WW-1:0] codec_wake = 0;

  acg_top #(.OUT_STREAMS(P_OUT), .IN_STREAMS(P_IN), .BIDIR_STREAMS(P_BI),
            .SDO_CODE(P_SDO), .ADDR64(P_A64), .VER_MAJOR(P_MAJ), .VER_MINOR(P_MIN),
            .ENTER_CYC(ENT), .EXIT_CYC(EXT), .NUM_STREAMS(NS), .WAKE_W(WW)) dut (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .link_rst_n(link_rst_n), .stream_run(stream_run),
    .ring_run(ring_run), .flush_req(flush_req), .flush_done(flush_done),
    .unsol_valid(unsol_valid), .unsol_accept(unsol_accept), .codec_wake(codec_wake));

  always #10 clk = ~clk;

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  event ev;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [31:0] observe(int kind);
    case (kind)
      0: return rdata;
      1: return {31'b0, link_rst_n};
      2: return {31'b0, flush_req};
      default: return {31'b0, unsol_accept};
    endcase
  endfunction

  initial forever begin
    @(ev);
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = observe(it.kind);
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(int kind, logic [31:0] exp, string tag);
    q.push_back('{kind, exp, tag});
    ->ev;
    #1;
  endtask
  task automatic exp_rd(logic [7:0] a, logic [31:0] exp, string tag);
    addr = a; #1; push(0, exp, tag);
  endtask
  task automatic step();
    @(negedge clk); #1;
  endtask
  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0; #1;
  endtask
  task automatic do_flush();
    wr(8'h08, 32'h103);
    flush_done = 1; step(); flush_done = 0;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] id;
    id = (P_MAJ << 24) | (P_MIN << 16) | (P_OUT << 12) | (P_IN << 8) |
         (P_BI << 3) | (P_SDO << 1) | P_A64;
    repeat (3) @(negedge clk);
    por_n = 1; #1;
    exp_rd(8'h00, id, "R1 identity word");
    exp_rd(8'h08, 0, "R2 control after por");
    push(1, 0, "R2 link reset after por");
    // R5: enable and flush writes ignored while in reset
    wr(8'h08, 32'h102);
    exp_rd(8'h08, 0, "R5 ctl write in reset ignored");
    // R3: exit sequence
    wr(8'h08, 32'h103);
    push(1, 1, "R3 link released after write");
    for (int j = 0; j < EXT; j++) begin
      exp_rd(8'h08, 0, "R3 bit0 still 0 during exit");
      step();
    end
    exp_rd(8'h08, 1, "R3 R5 bit0 reads 1, enable bits not latched");
    // R5: bit0 write during exit ignored; check reset write ignored when not in sequence is N/A
    // R7
    wr(8'h08, 32'hFFFF_FEFD);
    exp_rd(8'h08, 1, "R7 reserved bits read 0");
    // R8
    unsol_valid = 1; #1;
    push(3, 0, "R8 dropped when disabled");
    wr(8'h08, 32'h101);
    push(3, 1, "R8 accepted when enabled");
    exp_rd(8'h08, 32'h101, "R8 enable readback");
    unsol_valid = 0; #1;
    push(3, 0, "R8 no accept without valid");
    // R10
    stream_run[3] = 1;
    wr(8'h08, 32'h103);
    push(2, 0, "R10 flush blocked by stream run");
    stream_run = 0; ring_run = 2'b01;
    wr(8'h08, 32'h103);
    push(2, 0, "R10 flush blocked by ring run");
    exp_rd(8'h08, 32'h101, "R10 flush bit stays 0");
    ring_run = 0;
    // R9
    wr(8'h08, 32'h103);
    push(2, 1, "R9 flush_req raised");
    exp_rd(8'h08, 32'h103, "R9 flush bit reads 1");
    step();
    push(2, 1, "R9 flush_req held");
    exp_rd(8'h14, 0, "R9 status 0 while open");
    flush_done = 1; step(); flush_done = 0;
    push(2, 0, "R9 flush_req dropped on done");
    exp_rd(8'h14, 1, "R9 status set");
    exp_rd(8'h08, 32'h101, "R9 flush bit cleared");
    // R11
    wr(8'h14, 0);
    exp_rd(8'h14, 1, "R11 write 0 keeps status");
    wr(8'h14, 1);
    exp_rd(8'h14, 0, "R11 write 1 clears status");
    // R6 setup
    wr(8'h0C, 32'h1234);
    @(negedge clk); codec_wake = 15'h0008; @(negedge clk); codec_wake = 0; #1;
    exp_rd(8'h10, 32'h8, "R6 wake status set by input");
    // R4: status set, second flush left open, enable on
    do_flush();
    wr(8'h08, 32'h103);
    push(2, 1, "R4 flush open before reset");
    wr(8'h08, 32'h100);
    push(1, 0, "R4 link asserted at entry");
    push(2, 0, "R4 flush cleared at entry");
    exp_rd(8'h14, 0, "R4 status cleared at entry");
    for (int j = 0; j < ENT; j++) begin
      exp_rd(8'h08, 1, "R4 bit0 still 1 during entry, others cleared");
      step();
    end
    exp_rd(8'h08, 0, "R4 bit0 reads 0 after entry");
    // R5 in reset
    wr(8'h08, 32'h100);
    unsol_valid = 1; #1;
    push(3, 0, "R5 enable write in reset ignored");
    unsol_valid = 0;
    // R6 survival and writability in reset
    exp_rd(8'h0C, 32'h1234, "R6 wake enable survives ctl reset");
    exp_rd(8'h10, 32'h8, "R6 wake status survives ctl reset");
    wr(8'h0C, 32'h0055);
    exp_rd(8'h0C, 32'h55, "R6 wake enable writable in reset");
    wr(8'h10, 32'h8);
    exp_rd(8'h10, 0, "R6 wake status cleared by write 1");
    @(negedge clk); codec_wake = 15'h0001; @(negedge clk); codec_wake = 0; #1;
    @(negedge clk); por_n = 0; step(); step(); por_n = 1; #1;
    exp_rd(8'h0C, 0, "R6 wake enable cleared by por");
    exp_rd(8'h10, 0, "R6 wake status cleared by por");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule